// File: doc/BRIEF.md
# Parallel acquisition port word packer

This block receives samples from an external parallel source over up to 20 data lines. A port clock and an active-low hold line come with the data. The block runs in the system clock domain. It watches the port clock for the configured edge and takes one sample on each such edge where hold is low.

Samples are packed into 32-bit words. A 2-bit mode selects one of four layouts. Finished words go into a six-entry receive queue, which a memory or DMA consumer drains through a valid/ready interface. If a word finishes while the queue is full, the word is lost and a sticky flag records the loss.

Configuration inputs set the mode, the edge polarity and the enable, and clear the loss flag.

Top module: `pkp_top`

## Requirements
- R1: Mode 2'b00 packs four samples taken from portData[7:0]. The first sample goes to bits 31..24, the second to 23..16, the third to 15..8 and the fourth to 7..0.
- R2: Mode 2'b01 packs two samples taken from portData[15:0]. The first goes to bits 31..16 and the second to 15..0.
- R3: Mode 2'b10 packs three samples. It takes portData[9:0] into bits 31..22, then portData[10:0] into bits 21..11, then portData[10:0] into bits 10..0.
- R4: Mode 2'b11 turns each sample into one word. portData[19:0] goes to bits 31..12, and bits 11..0 are zero.
- R5: A sample is taken only on a system clock edge where the sampled port clock shows the selected transition and holdN is low. The transition is low-to-high when cfgFallEdge is 0 and high-to-low when it is 1. A transition seen while holdN is high takes nothing and does not advance packing.
- R6: Finished words enter a 6-deep first-in first-out queue. The head word appears on outData in the cycle after it is written. outValid is high while the queue holds a word, and a word leaves on a clock edge where outValid and outReady are both high.
- R7: A word that finishes while the queue already holds 6 words is dropped, and overflow is set. overflow stays high until a cycle with cfgClearOvf high. If a drop and a clear happen in the same cycle, overflow stays set.
- R8: If cfgMode differs from its value in the previous cycle, the partly packed word is discarded, packing restarts at the first slot, and no sample is taken in that cycle.
- R9: After reset, outValid and overflow are low and packing starts at the first slot.
- R10: While cfgEnable is low, no sample is taken and any partly packed word is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | Port enable |
| cfgMode | input | 2 | Packing layout select |
| cfgFallEdge | input | 1 | 1 selects the high-to-low port clock transition |
| cfgClearOvf | input | 1 | Clears the overflow flag |
| portClk | input | 1 | External port clock, sampled by clk |
| holdN | input | 1 | Active-low sample qualifier |
| portData | input | 20 | Parallel sample lines |
| outValid | output | 1 | Queue head is valid |
| outReady | input | 1 | Consumer accepts the head word |
| outData | output | 32 | Queue head word |
| overflow | output | 1 | Sticky lost-word flag |

## Verification
Each mode gets samples whose bits above the slot width are set. A correct word therefore shows that the unused upper lines are masked and that the slots sit in the right order.

The same samples are also sent with hold high and with the port enable low. These runs separate a real capture from a port clock transition that must be ignored. Runs with each edge polarity show that the wrong transition takes nothing.

A mode change in the middle of a word checks that partial data is thrown away rather than merged into the next word. The queue is filled to seven words with the consumer stalled, which shows exactly which word is dropped, and overflow is then cleared.

// File: rtl/pkp_pkg.sv
package pkp_pkg;
  localparam int IN_W   = 20;
  localparam int WORD_W = 32;
  localparam int SLOT_W = 2;

  typedef enum logic [1:0] {
    MODE_BYTE  = 2'b00,
    MODE_HALF  = 2'b01,
    MODE_TRI   = 2'b10,
    MODE_WIDE  = 2'b11
  } packMode_t;

  typedef struct packed {
    logic               capture;
    logic               finish;
    logic               flush;
    logic [SLOT_W-1:0]  slotIdx;
  } packStrobe_t;
endpackage

// File: rtl/pkp_ctrl.sv
module pkp_ctrl
  import pkp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgEnable,
  input  logic [1:0]  cfgMode,
  input  logic        cfgFallEdge,
  input  logic        portClk,
  input  logic        holdN,
  output packStrobe_t strobe
);
  logic              prevClk;
  logic [1:0]        prevMode;
  logic [SLOT_W-1:0] slotCnt;
  logic [SLOT_W-1:0] lastSlot;
  logic              edgeSeen;
  logic              modeChg;

  always_comb begin
    case (packMode_t'(cfgMode))
      MODE_BYTE: lastSlot = 2'd3;
      MODE_HALF: lastSlot = 2'd1;
      MODE_TRI:  lastSlot = 2'd2;
      default:   lastSlot = 2'd0;
    endcase
  end

  assign edgeSeen = cfgFallEdge ? (prevClk & ~portClk) : (~prevClk & portClk);
  assign modeChg  = (cfgMode != prevMode);

  always_comb begin
    strobe.flush   = ~cfgEnable | modeChg;
    strobe.capture = edgeSeen & ~holdN & ~strobe.flush;
    strobe.finish  = strobe.capture & (slotCnt == lastSlot);
    strobe.slotIdx = slotCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevClk  <= 1'b0;
      prevMode <= 2'b00;
      slotCnt  <= '0;
    end else begin
      prevClk  <= portClk;
      prevMode <= cfgMode;
      if (strobe.flush || strobe.finish) slotCnt <= '0;
      else if (strobe.capture)           slotCnt <= slotCnt + 1'b1;
    end
  end
endmodule

// File: rtl/pkp_datapath.sv
module pkp_datapath
  import pkp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cfgMode,
  input  logic [IN_W-1:0]   portData,
  input  packStrobe_t       strobe,
  output logic [WORD_W-1:0] packedWord
);
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] nextAcc;

  always_comb begin
    case (packMode_t'(cfgMode))
      MODE_BYTE: nextAcc = {acc[23:0], portData[7:0]};
      MODE_HALF: nextAcc = {acc[15:0], portData[15:0]};
      MODE_TRI:  nextAcc = (strobe.slotIdx == '0) ? {22'd0, portData[9:0]}
                                                  : {acc[20:0], portData[10:0]};
      default:   nextAcc = {portData[19:0], 12'd0};
    endcase
  end

  assign packedWord = nextAcc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               acc <= '0;
    else if (strobe.flush || strobe.finish)  acc <= '0;
    else if (strobe.capture)                 acc <= nextAcc;
  end
endmodule

// File: rtl/pkp_fifo.sv
module pkp_fifo #(
  parameter int DEPTH  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popReady,
  input  logic              clearOvf,
  output logic              headValid,
  output logic [DATA_W-1:0] headData,
  output logic              ovfFlag
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  fill;
  logic              full, doWrite, doRead, drop;

  assign full      = (fill == CNT_W'(DEPTH));
  assign doWrite   = push & ~full;
  assign drop      = push & full;
  assign headValid = (fill != '0);
  assign doRead    = headValid & popReady;
  assign headData  = mem[rdPtr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doWrite) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fill    <= '0;
      ovfFlag <= 1'b0;
    end else begin
      if (doWrite) wrPtr <= bump(wrPtr);
      if (doRead)  rdPtr <= bump(rdPtr);
      fill <= fill + CNT_W'(doWrite) - CNT_W'(doRead);
      if (drop)          ovfFlag <= 1'b1;
      else if (clearOvf) ovfFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/pkp_top.sv
module pkp_top
  import pkp_pkg::*;
#(
  parameter int FIFO_DEPTH = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgEnable,
  input  logic [1:0]  cfgMode,
  input  logic        cfgFallEdge,
  input  logic        cfgClearOvf,
  input  logic        portClk,
  input  logic        holdN,
  input  logic [19:0] portData,
  output logic        outValid,
  input  logic        outReady,
  output logic [31:0] outData,
  output logic        overflow
);
  packStrobe_t       strobe;
  logic [WORD_W-1:0] packedWord;

  pkp_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgMode(cfgMode),
    .cfgFallEdge(cfgFallEdge), .portClk(portClk), .holdN(holdN), .strobe(strobe)
  );

  pkp_datapath dp_i (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .portData(portData),
    .strobe(strobe), .packedWord(packedWord)
  );

  pkp_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(WORD_W)) fifo_i (
    .clk(clk), .rstN(rstN), .push(strobe.finish), .pushData(packedWord),
    .popReady(outReady), .clearOvf(cfgClearOvf), .headValid(outValid),
    .headData(outData), .ovfFlag(overflow)
  );
endmodule

// File: rtl/pkp_checker.sv
module pkp_checker (
  input logic        clk,
  input logic        rstN,
  input logic        cfgEnable,
  input logic        cfgClearOvf,
  input logic        holdN,
  input logic        outValid,
  input logic        outReady,
  input logic [31:0] outData,
  input logic        overflow
);
  assert_reset_state_R9: assert property (@(posedge clk)
    !rstN |=> (!outValid && !overflow));

  assert_head_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !cfgClearOvf) |=> overflow);

  assert_ovf_needs_data_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(outValid));

  assert_hold_no_push_R5: assert property (@(posedge clk) disable iff (!rstN)
    (holdN && !outReady) |=> (outValid == $past(outValid)));

  assert_disabled_no_push_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgEnable && !outReady) |=> (outValid == $past(outValid)));
endmodule

bind pkp_top pkp_checker chk_i (
  .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgClearOvf(cfgClearOvf),
  .holdN(holdN), .outValid(outValid), .outReady(outReady),
  .outData(outData), .overflow(overflow)
);

// File: tb/pkp_top_tb_top.sv
module pkp_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgEnable = 1'b0;
  logic [1:0]  cfgMode = 2'b00;
  logic        cfgFallEdge = 1'b0;
  logic        cfgClearOvf = 1'b0;
  logic        portClk = 1'b0;
  logic        holdN = 1'b1;
  logic [19:0] portData = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [31:0] outData;
  logic        overflow;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pkp_top dut_i (.*);

  // behavioural reference model
  logic [31:0] mQ[$];
  logic [19:0] mSmp[4];
  int          mCnt;
  bit          mPrevClk, mOvf;
  logic [1:0]  mPrevMode;

  function automatic int needOf(input logic [1:0] m);
    case (m)
      2'b00: return 4;
      2'b01: return 2;
      2'b10: return 3;
      default: return 1;
    endcase
  endfunction

  function automatic logic [31:0] build(input logic [1:0] m);
    case (m)
      2'b00: return {mSmp[0][7:0], mSmp[1][7:0], mSmp[2][7:0], mSmp[3][7:0]};
      2'b01: return {mSmp[0][15:0], mSmp[1][15:0]};
      2'b10: return {mSmp[0][9:0], mSmp[1][10:0], mSmp[2][10:0]};
      default: return {mSmp[0], 12'h000};
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mQ.delete(); mCnt = 0; mPrevClk = 0; mOvf = 0; mPrevMode = 2'b00;
    end else begin
      bit edgeNow, flush, cap, fin, wasFull;
      logic [31:0] w;
      edgeNow = cfgFallEdge ? (mPrevClk && !portClk) : (!mPrevClk && portClk);
      flush   = !cfgEnable || (cfgMode != mPrevMode);
      cap     = edgeNow && !holdN && !flush;
      fin     = 0;
      w       = '0;
      if (flush) mCnt = 0;
      if (cap) begin
        mSmp[mCnt] = portData;
        if (mCnt == needOf(cfgMode) - 1) begin
          fin = 1; w = build(cfgMode); mCnt = 0;
        end else mCnt++;
      end
      wasFull = (mQ.size() == 6);
      if (mQ.size() != 0 && outReady) void'(mQ.pop_front());
      if (fin) begin
        if (wasFull) mOvf = 1;
        else mQ.push_back(w);
      end else if (cfgClearOvf) mOvf = 0;
      mPrevClk  = portClk;
      mPrevMode = cfgMode;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (outValid !== (mQ.size() != 0)) begin
        errors++; $display("FAIL R6 outValid act %0b exp %0b", outValid, mQ.size() != 0);
      end
      if (mQ.size() != 0) begin
        checks++;
        if (outData !== mQ[0]) begin
          errors++; $display("FAIL R1 head word act %h exp %h", outData, mQ[0]);
        end
      end
      checks++;
      if (overflow !== mOvf) begin
        errors++; $display("FAIL R7 overflow act %0b exp %0b", overflow, mOvf);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++; $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [19:0] d, input bit hold);
    @(negedge clk); portClk = cfgFallEdge; holdN = 1'b1;
    @(negedge clk); portClk = !cfgFallEdge; holdN = hold; portData = d;
    @(negedge clk); holdN = 1'b1;
  endtask

  task automatic drain();
    @(negedge clk); outReady = 1'b1;
    while (outValid) @(negedge clk);
    outReady = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 valid", {31'd0, outValid}, 32'd0);
    check("R9 overflow", {31'd0, overflow}, 32'd0);
    rstN = 1'b1;
    cfgEnable = 1'b1;
    @(negedge clk);

    // R1 byte mode, upper lines set
    cfgMode = 2'b00; @(negedge clk);
    pulse(20'hFFF11, 0); pulse(20'hABC22, 0); pulse(20'h00033, 0);
    check("R1 partial", {31'd0, outValid}, 32'd0);
    pulse(20'h12344, 0);
    check("R1 word", outData, 32'h11223344);
    drain();

    // R2 half mode
    cfgMode = 2'b01; @(negedge clk);
    pulse(20'hF1234, 0); pulse(20'h05678, 0);
    check("R2 word", outData, 32'h12345678);
    drain();

    // R3 uneven mode
    cfgMode = 2'b10; @(negedge clk);
    pulse(20'hFFFFF, 0); pulse(20'hFF800, 0); pulse(20'h007FF, 0);
    check("R3 word", outData, 32'hFFC007FF);
    drain();

    // R4 wide mode
    cfgMode = 2'b11; @(negedge clk);
    pulse(20'hABCDE, 0);
    check("R4 word", outData, 32'hABCDE000);
    drain();

    // R5 hold high takes nothing
    pulse(20'h12345, 1);
    check("R5 hold", {31'd0, outValid}, 32'd0);
    // R5 falling edge selection
    cfgFallEdge = 1'b1; @(negedge clk);
    pulse(20'h54321, 0);
    check("R5 falling", outData, 32'h54321000);
    drain();
    // rising transition while falling selected: no capture
    @(negedge clk); portClk = 1'b0; @(negedge clk); portClk = 1'b1; holdN = 1'b0;
    @(negedge clk); holdN = 1'b1;
    check("R5 wrong edge", {31'd0, outValid}, 32'd0);
    cfgFallEdge = 1'b0; @(negedge clk);

    // R10 disabled
    cfgEnable = 1'b0; @(negedge clk);
    pulse(20'h11111, 0);
    check("R10 disabled", {31'd0, outValid}, 32'd0);
    cfgEnable = 1'b1; @(negedge clk);

    // R8 mode change discards partial
    cfgMode = 2'b00; @(negedge clk);
    pulse(20'h000AA, 0); pulse(20'h000BB, 0);
    cfgMode = 2'b01; @(negedge clk);
    pulse(20'h0CAFE, 0); pulse(20'h0BEEF, 0);
    check("R8 restart", outData, 32'hCAFEBEEF);
    drain();

    // R6/R7 fill and overflow
    cfgMode = 2'b11; @(negedge clk);
    for (int i = 0; i < 7; i++) pulse(20'(i + 1), 0);
    check("R7 overflow set", {31'd0, overflow}, 32'd1);
    check("R6 head order", outData, 32'h00001000);
    @(negedge clk); cfgClearOvf = 1'b1; @(negedge clk); cfgClearOvf = 1'b0;
    check("R7 overflow cleared", {31'd0, overflow}, 32'd0);
    drain();
    check("R6 empty", {31'd0, outValid}, 32'd0);

    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++;
    checks++;
    $display("FAIL watchdog act %0d exp below 20000", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule